// File: doc/BRIEF.md
# Accumulator Machine Four-Phase Controller

This block sequences a minimal single-accumulator machine. It owns a program counter, an instruction register, one accumulator and one small memory that holds both code and data. Every instruction passes through four equal phases: fetch, decode, prepare and execute. In fetch the memory is addressed by the program counter and the instruction register captures the word. From decode onward the memory is addressed by the instruction's address field. The program counter steps forward during decode. The operation is chosen during prepare and committed during execute.

A program is placed in memory through a load port while reset is held. When reset is released the machine runs from address zero. The current phase, the program counter, the memory address, the write strobe and the accumulator are visible at the ports, so each step can be observed.

An instruction word is an opcode (upper OPW bits) followed by an address field (lower AW bits). The opcodes are: 0x01 add, 0x02 subtract, 0x03 load, 0x04 store, 0x05 jump, 0x06 jump-if-zero, 0x07 shift right, 0x08 shift left, 0x09 clear. Any other code does nothing.

Top module: `acc_phase_cpu`

## Requirements
- R1: While reset is high at a clock edge, the controller returns to phase 0 (fetch) with the program counter and the accumulator at zero.
- R2: The phase output steps 0, 1, 2, 3 (fetch, decode, prepare, execute) and then wraps to 0. It advances once per clock.
- R3: In phase 0, mem_addr equals the program counter and addr_sel is 0. In phases 1 to 3, mem_addr equals the low AW bits of the fetched instruction and addr_sel is 1.
- R4: The program counter increments by one at the end of decode. Otherwise it changes only at the end of prepare, and only for a taken jump.
- R5: Add (0x01) and subtract (0x02) set the accumulator to the accumulator plus or minus M[field] at the end of execute, modulo 2^DW.
- R6: Load (0x03) sets the accumulator to M[field]. Store (0x04) raises mem_we during execute only and writes the accumulator to M[field].
- R7: Jump (0x05) sets the program counter to the field at the end of prepare.
- R8: Jump-if-zero (0x06) sets the program counter to the field only when the accumulator is zero. Otherwise execution continues at the next address.
- R9: Shift right (0x07) and shift left (0x08) move the accumulator one bit and fill with zero. Clear (0x09) zeroes the accumulator.
- R10: Any other opcode leaves the accumulator unchanged, and the program counter only increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Memory load strobe, used while reset is held |
| prog_addr | input | AW | Memory load address |
| prog_data | input | OPW+AW | Memory load word |
| phase | output | 2 | Current phase: 0 fetch, 1 decode, 2 prepare, 3 execute |
| addr_sel | output | 1 | Memory address source: 0 program counter, 1 instruction field |
| mem_addr | output | AW | Address presented to the memory |
| mem_we | output | 1 | Memory write strobe from a store |
| pc | output | AW | Program counter |
| acc | output | OPW+AW | Accumulator |

## Verification
The bench uses the default parameters: an 8-bit opcode, a 12-bit field and 256 memory words, which gives a 20-bit accumulator. With this width a subtraction that underflows and an addition that wraps back to zero both occur within a short program. The same program also reaches a taken and an untaken conditional jump, a store followed by a load of the same word, and an unassigned opcode. A backward jump runs the first instruction a second time, so the program counter's return to zero is exercised.

// File: rtl/acc_phase_cpu.sv
module acc_phase_cpu #(
  parameter int OPW = 8,
  parameter int AW = 12,
  parameter int MEM_WORDS = 256,
  localparam int DW = OPW + AW,
  localparam int MA = $clog2(MEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_addr,
  input  logic [DW-1:0] prog_data,
  output logic [1:0]    phase,
  output logic          addr_sel,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] acc
);
  localparam logic [1:0] PH_FETCH = 2'd0, PH_DEC = 2'd1, PH_PREP = 2'd2, PH_EXEC = 2'd3;
  localparam logic [OPW-1:0] OP_ADD = OPW'(1), OP_SUB = OPW'(2), OP_LDA = OPW'(3),
    OP_STA = OPW'(4), OP_JMP = OPW'(5), OP_JZ = OPW'(6), OP_SHR = OPW'(7),
    OP_SHL = OPW'(8), OP_CLR = OPW'(9);

  typedef enum logic [2:0] {AL_NONE, AL_ADD, AL_SUB, AL_PASS, AL_SHR, AL_SHL, AL_CLR} alu_t;

  logic [DW-1:0] mem [MEM_WORDS];
  logic [DW-1:0] ir, mem_rd, alu_out;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] acc_q;
  logic [1:0]    ph;
  alu_t          alu_sel, alu_dec;

  wire [OPW-1:0] opc = ir[DW-1:AW];
  wire [AW-1:0]  fld = ir[AW-1:0];
  wire           jump_take = (opc == OP_JMP) || (opc == OP_JZ && acc_q == '0);

  assign addr_sel = (ph != PH_FETCH);
  assign mem_addr = addr_sel ? fld : pc_q;
  assign mem_rd   = mem[mem_addr[MA-1:0]];
  assign mem_we   = (ph == PH_EXEC) && (opc == OP_STA);
  assign phase    = ph;
  assign pc       = pc_q;
  assign acc      = acc_q;

  always_comb begin
    case (opc)
      OP_ADD:  alu_dec = AL_ADD;
      OP_SUB:  alu_dec = AL_SUB;
      OP_LDA:  alu_dec = AL_PASS;
      OP_SHR:  alu_dec = AL_SHR;
      OP_SHL:  alu_dec = AL_SHL;
      OP_CLR:  alu_dec = AL_CLR;
      default: alu_dec = AL_NONE;
    endcase
  end

  always_comb begin
    case (alu_sel)
      AL_ADD:  alu_out = acc_q + mem_rd;
      AL_SUB:  alu_out = acc_q - mem_rd;
      AL_PASS: alu_out = mem_rd;
      AL_SHR:  alu_out = acc_q >> 1;
      AL_SHL:  alu_out = acc_q << 1;
      AL_CLR:  alu_out = '0;
      default: alu_out = acc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (prog_we) mem[prog_addr[MA-1:0]] <= prog_data;
    else if (mem_we) mem[fld[MA-1:0]] <= acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_FETCH;
      pc_q    <= '0;
      ir      <= '0;
      acc_q   <= '0;
      alu_sel <= AL_NONE;
    end else begin
      ph <= 2'(ph + 2'd1);
      case (ph)
        PH_FETCH: ir <= mem_rd;
        PH_DEC:   pc_q <= AW'(pc_q + 1'b1);
        PH_PREP: begin
          alu_sel <= alu_dec;
          if (jump_take) pc_q <= fld;
        end
        default: begin
          if (alu_sel != AL_NONE) acc_q <= alu_out;
          alu_sel <= AL_NONE;
        end
      endcase
    end
  end
endmodule

module acc_phase_cpu_chk #(
  parameter int AW = 12,
  parameter int DW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    phase,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] acc,
  input logic          mem_we
);
  // R2
  phase_ring_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phase == 2'($past(phase) + 2'd1));
  // R3
  fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
    phase == 2'd0 |-> mem_addr == pc);
  // R4
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd0 || phase == 2'd3) |=> $stable(pc));
  // R5
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd3 |=> $stable(acc));
  // R6
  write_slot_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> phase == 2'd3);
endmodule

bind acc_phase_cpu acc_phase_cpu_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .phase(phase), .pc(pc),
  .mem_addr(mem_addr), .acc(acc), .mem_we(mem_we)
);

// File: tb/acc_phase_cpu_tb_top.sv
module acc_phase_cpu_tb_top;
  localparam int AW = 12;
  localparam int DW = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog_we = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic [DW-1:0] prog_data = '0;
  logic [1:0] phase;
  logic addr_sel, mem_we;
  logic [AW-1:0] mem_addr, pc;
  logic [DW-1:0] acc;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  acc_phase_cpu dut_i (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .phase(phase), .addr_sel(addr_sel),
    .mem_addr(mem_addr), .mem_we(mem_we), .pc(pc), .acc(acc)
  );

  // {address, word}
  localparam logic [31:0] PROG [19] = '{
    {12'h000, 20'h03040}, {12'h001, 20'h01041}, {12'h002, 20'h02042},
    {12'h003, 20'h07000}, {12'h004, 20'h08000}, {12'h005, 20'h04043},
    {12'h006, 20'h09000}, {12'h007, 20'h0600A}, {12'h008, 20'h01041},
    {12'h009, 20'h01041}, {12'h00A, 20'h03043}, {12'h00B, 20'h06008},
    {12'h00C, 20'hEE000}, {12'h00D, 20'h01044}, {12'h00E, 20'h05000},
    {12'h040, 20'h00005}, {12'h041, 20'h00003}, {12'h042, 20'h0000A},
    {12'h044, 20'h00002}
  };

  // {store, field, pc after, acc after}
  localparam logic [44:0] STEPS [14] = '{
    {1'b0, 12'h040, 12'h001, 20'h00005},  // R6 load
    {1'b0, 12'h041, 12'h002, 20'h00008},  // R5 add
    {1'b0, 12'h042, 12'h003, 20'hFFFFE},  // R5 subtract underflow
    {1'b0, 12'h000, 12'h004, 20'h7FFFF},  // R9 shift right
    {1'b0, 12'h000, 12'h005, 20'hFFFFE},  // R9 shift left
    {1'b1, 12'h043, 12'h006, 20'hFFFFE},  // R6 store
    {1'b0, 12'h000, 12'h007, 20'h00000},  // R9 clear
    {1'b0, 12'h00A, 12'h00A, 20'h00000},  // R8 taken
    {1'b0, 12'h043, 12'h00B, 20'hFFFFE},  // R6 load of stored word
    {1'b0, 12'h008, 12'h00C, 20'hFFFFE},  // R8 not taken
    {1'b0, 12'h000, 12'h00D, 20'hFFFFE},  // R10 unknown opcode
    {1'b0, 12'h044, 12'h00E, 20'h00000},  // R5 add wrap
    {1'b0, 12'h000, 12'h000, 20'h00000},  // R7 jump
    {1'b0, 12'h040, 12'h001, 20'h00005}   // R7 rerun from zero
  };
  localparam int STEP_REQ [14] = '{6, 5, 5, 9, 9, 6, 9, 8, 6, 8, 10, 5, 7, 7};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_step(input int i);
    logic [AW-1:0] pc0;
    string rt;
    rt = $sformatf("R%0d step %0d", STEP_REQ[i], i);
    pc0 = pc;
    chk("R2 fetch phase", 32'(phase), 32'd0);
    chk("R3 fetch addr", 32'(mem_addr), 32'(pc0));
    chk("R3 fetch sel", 32'(addr_sel), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R2 decode phase", 32'(phase), 32'd1);
    chk("R3 field addr", 32'(mem_addr), 32'(STEPS[i][43:32]));
    chk("R3 field sel", 32'(addr_sel), 32'd1);
    @(posedge clk); @(negedge clk);
    chk("R2 prepare phase", 32'(phase), 32'd2);
    chk("R4 increment", 32'(pc), 32'(AW'(pc0 + 1'b1)));
    @(posedge clk); @(negedge clk);
    chk("R2 execute phase", 32'(phase), 32'd3);
    chk({rt, " write strobe"}, 32'(mem_we), 32'(STEPS[i][44]));
    @(posedge clk); @(negedge clk);
    chk({rt, " pc"}, 32'(pc), 32'(STEPS[i][31:20]));
    chk({rt, " acc"}, 32'(acc), 32'(STEPS[i][19:0]));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    foreach (PROG[k]) begin
      prog_we = 1'b1;
      prog_addr = PROG[k][31:20];
      prog_data = PROG[k][19:0];
      @(negedge clk);
    end
    prog_we = 1'b0;
    chk("R1 reset phase", 32'(phase), 32'd0);
    chk("R1 reset pc", 32'(pc), 32'd0);
    chk("R1 reset acc", 32'(acc), 32'd0);
    rst = 1'b0;
    for (int i = 0; i < 14; i++) run_step(i);
    // mid-instruction reset, r1_ check
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 midrun phase", 32'(phase), 32'd0);
    chk("R1 midrun pc", 32'(pc), 32'd0);
    chk("R1 midrun acc", 32'(acc), 32'd0);
    rst = 1'b0;
    run_step(0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule